// File: doc/BRIEF.md
# Multiplexed External Memory Bus Sequencer

This block produces the external bus timing for a small 8-bit processor core that reaches code and data memory over one shared byte carrying low address and data, plus a separate high address byte. The sequencer runs on the oscillator clock, so one clock is one oscillator period. A machine cycle is 12 clocks. It is split into two bus slots of six phases each, numbered 0 to 5 within the slot. The strobe cadence never stops. Every slot not claimed by a data transfer emits an address latch pulse, and in external-code mode it also emits a program store pulse.

The core hands over work on two streams. The code-fetch stream carries a 16-bit address. The data stream carries an address, a read or write flag, a flag for 8-bit or 16-bit addressing, and write data. Both streams use valid/ready. Ready is offered only in the last phase of a slot, and a transfer happens on a clock edge where both valid and ready are high. The core holds valid and its payload steady until that edge. The bus cannot stall, so the two return streams (code bytes and read data) are single-cycle valid pulses with no back-pressure.

A data transfer occupies two consecutive slots. The first slot latches the address and starts the read or write strobe. The second slot skips its latch pulse and carries the rest of the strobe. The program store pulses of both slots are skipped. A reset is taken only after the reset input has stayed high for two full machine cycles. The external-code select input is captured while that reset is active.

Top module: `xbus_sequencer`

## Requirements
- R1: Reset is accepted only once `rst_in` has been sampled high on 24 consecutive clock edges. A shorter high pulse leaves the strobe cadence undisturbed.
- R2: While reset is active, `ale_o` is low, `psen_n_o`, `rd_n_o` and `wr_n_o` are high, and `ad_oe_o` and `hi_addr_oe_o` are low. The first clock after the release edge is phase 0 of a new slot.
- R3: `ext_code_n_i` is captured while reset is active. Low selects external code, high selects internal code. In internal mode `fetch_ready_o` is never high.
- R4: `ale_o` is high in phases 1 and 2 of every slot except the second slot of a data transfer, so a machine cycle with no data transfer has exactly two latch pulses.
- R5: In external mode `psen_n_o` is low in phases 3 to 5 of every slot that is not part of a data transfer. In internal mode it stays high.
- R6: A fetch or data request accepted at the end of a slot owns the next slot. In phases 0 to 2 of that slot, `ad_o` carries address bits 7:0 with `ad_oe_o` high.
- R7: In a fetch slot, `ad_i` is sampled on the edge that ends phase 5. `code_valid_o` is high for exactly the following clock, with that byte on `code_data_o`.
- R8: A data transfer drives its strobe low from phase 3 of its first slot through phase 5 of its second slot (9 clocks). It removes one latch pulse and two program store pulses.
- R9: During a write, `ad_o` carries the write data with `ad_oe_o` high for the whole strobe. During a read, `ad_oe_o` is low, `ad_i` is sampled on the edge that ends the strobe, and `rdata_valid_o` pulses for one clock with that byte.
- R10: `hi_addr_o` carries address bits 15:8 with `hi_addr_oe_o` high for a fetch slot and for both slots of a 16-bit data transfer. For an 8-bit data transfer `hi_addr_oe_o` is low.
- R11: A data request takes precedence: while `dreq_valid_i` is high, `fetch_ready_o` is low. No request is accepted at the end of the first slot of a data transfer.
- R12: `rd_n_o` and `wr_n_o` are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_in | input | 1 | Reset request, filtered over two machine cycles |
| ext_code_n_i | input | 1 | Code source select, captured during reset (0 = external) |
| fetch_valid_i | input | 1 | Code fetch request valid |
| fetch_ready_o | output | 1 | Code fetch request accepted this edge |
| fetch_addr_i | input | 16 | Code fetch address |
| code_valid_o | output | 1 | Fetched code byte valid (one clock) |
| code_data_o | output | 8 | Fetched code byte |
| dreq_valid_i | input | 1 | Data request valid |
| dreq_ready_o | output | 1 | Data request accepted this edge |
| dreq_write_i | input | 1 | 1 = write, 0 = read |
| dreq_wide_i | input | 1 | 1 = 16-bit address, 0 = 8-bit address |
| dreq_addr_i | input | 16 | Data address |
| dreq_wdata_i | input | 8 | Write data |
| rdata_valid_o | output | 1 | Read data valid (one clock) |
| rdata_o | output | 8 | Read data |
| ale_o | output | 1 | Address latch strobe, active high |
| psen_n_o | output | 1 | Program store strobe, active low |
| rd_n_o | output | 1 | Data read strobe, active low |
| wr_n_o | output | 1 | Data write strobe, active low |
| ad_o | output | 8 | Multiplexed low address / data out |
| ad_oe_o | output | 1 | Drive enable for `ad_o` |
| ad_i | input | 8 | Multiplexed data in |
| hi_addr_o | output | 8 | High address byte |
| hi_addr_oe_o | output | 1 | Drive enable for `hi_addr_o` |

## Verification
Every result follows from the slot position. A request accepted at the edge ending phase 5 shows up on the bus from the very next clock, which is phase 0 of its slot. A code byte returns six clocks after acceptance. Read data returns twelve clocks after acceptance, and the write strobe releases at that same point. The bench keeps its own phase count, started at the reset release edge. It drives inputs and samples outputs on falling edges, and it compares each pin against the value that phase calls for, including the skipped latch and program store pulses and the cadence across an ignored short reset pulse.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  typedef enum logic [1:0] {
    SLOT_IDLE  = 2'd0,
    SLOT_FETCH = 2'd1,
    SLOT_DADDR = 2'd2,
    SLOT_DSTRB = 2'd3
  } slot_e;

  localparam int PH_PER_SLOT  = 6;
  localparam int SLOTS_PER_MC = 2;
  localparam int PH_PER_MC    = PH_PER_SLOT * SLOTS_PER_MC;
  localparam int QW           = $clog2(PH_PER_SLOT);

  localparam logic [QW-1:0] Q_FIRST    = QW'(0);
  localparam logic [QW-1:0] Q_ALE_A    = QW'(1);
  localparam logic [QW-1:0] Q_ALE_B    = QW'(2);
  localparam logic [QW-1:0] Q_ADDR_END = QW'(2);
  localparam logic [QW-1:0] Q_STRB     = QW'(3);
  localparam logic [QW-1:0] Q_LAST     = QW'(PH_PER_SLOT - 1);
endpackage

// File: rtl/xbus_reset_filter.sv
module xbus_reset_filter #(
  parameter int HOLD = 24
) (
  input  logic clk,
  input  logic rst_in,
  output logic seq_rst_o
);
  localparam int CW = $clog2(HOLD + 1);
  localparam logic [CW-1:0] HOLD_C = CW'(HOLD);

  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (!rst_in)
      run_cnt <= '0;
    else if (run_cnt != HOLD_C)
      run_cnt <= run_cnt + 1'b1;
  end

  assign seq_rst_o = (run_cnt == HOLD_C);
endmodule

// File: rtl/xbus_phase_gen.sv
module xbus_phase_gen
  import xbus_pkg::*;
(
  input  logic          clk,
  input  logic          seq_rst,
  output logic [QW-1:0] q_o,
  output logic          last_o
);
  logic [QW-1:0] q;

  always_ff @(posedge clk) begin
    if (seq_rst)
      q <= Q_FIRST;
    else if (q == Q_LAST)
      q <= Q_FIRST;
    else
      q <= q + 1'b1;
  end

  assign q_o    = q;
  assign last_o = (q == Q_LAST);

  assert_wrap_R4: assert property (@(posedge clk) disable iff (seq_rst)
    (q == Q_LAST) |=> (q == Q_FIRST));
endmodule

// File: rtl/xbus_slot_ctrl.sv
module xbus_slot_ctrl
  import xbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              seq_rst,
  input  logic              last_i,
  input  logic              ext_code_n_i,
  input  logic              fetch_valid_i,
  output logic              fetch_ready_o,
  input  logic [ADDR_W-1:0] fetch_addr_i,
  output logic              code_valid_o,
  output logic [DATA_W-1:0] code_data_o,
  input  logic              dreq_valid_i,
  output logic              dreq_ready_o,
  input  logic              dreq_write_i,
  input  logic              dreq_wide_i,
  input  logic [ADDR_W-1:0] dreq_addr_i,
  input  logic [DATA_W-1:0] dreq_wdata_i,
  output logic              rdata_valid_o,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [DATA_W-1:0] ad_i,
  output logic              ext_mode_o,
  output slot_e             kind_o,
  output logic [ADDR_W-1:0] cur_addr_o,
  output logic              cur_write_o,
  output logic              cur_wide_o,
  output logic [DATA_W-1:0] cur_wdata_o
);
  slot_e             kind;
  logic              ext_q;
  logic [ADDR_W-1:0] cur_addr;
  logic              cur_write, cur_wide;
  logic [DATA_W-1:0] cur_wdata;
  logic              take_code, take_read;

  assign dreq_ready_o  = !seq_rst && last_i && (kind != SLOT_DADDR);
  assign fetch_ready_o = !seq_rst && last_i && (kind != SLOT_DADDR)
                         && ext_q && !dreq_valid_i;
  assign take_code = last_i && (kind == SLOT_FETCH);
  assign take_read = last_i && (kind == SLOT_DSTRB) && !cur_write;

  always_ff @(posedge clk) begin
    if (seq_rst) begin
      kind          <= SLOT_IDLE;
      ext_q         <= !ext_code_n_i;
      code_valid_o  <= 1'b0;
      rdata_valid_o <= 1'b0;
      cur_write     <= 1'b0;
      cur_wide      <= 1'b0;
    end else begin
      code_valid_o  <= take_code;
      rdata_valid_o <= take_read;
      if (last_i) begin
        if (kind == SLOT_DADDR) begin
          kind <= SLOT_DSTRB;
        end else if (dreq_valid_i) begin
          kind      <= SLOT_DADDR;
          cur_addr  <= dreq_addr_i;
          cur_write <= dreq_write_i;
          cur_wide  <= dreq_wide_i;
          cur_wdata <= dreq_wdata_i;
        end else if (fetch_valid_i && ext_q) begin
          kind      <= SLOT_FETCH;
          cur_addr  <= fetch_addr_i;
          cur_write <= 1'b0;
        end else begin
          kind <= SLOT_IDLE;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!seq_rst && take_code) code_data_o <= ad_i;
    if (!seq_rst && take_read) rdata_o     <= ad_i;
  end

  assign ext_mode_o  = ext_q;
  assign kind_o      = kind;
  assign cur_addr_o  = cur_addr;
  assign cur_write_o = cur_write;
  assign cur_wide_o  = cur_wide;
  assign cur_wdata_o = cur_wdata;

  assert_ready_last_R6: assert property (@(posedge clk) disable iff (seq_rst)
    (dreq_ready_o || fetch_ready_o) |-> last_i);
  assert_strobe_follows_R8: assert property (@(posedge clk) disable iff (seq_rst)
    (kind == SLOT_DADDR && last_i) |=> (kind == SLOT_DSTRB));
  assert_code_pulse_R7: assert property (@(posedge clk) disable iff (seq_rst)
    code_valid_o |=> !code_valid_o);
  assert_data_first_R11: assert property (@(posedge clk) disable iff (seq_rst)
    (dreq_valid_i && dreq_ready_o) |-> !fetch_ready_o);
  assert_internal_nofetch_R3: assert property (@(posedge clk) disable iff (seq_rst)
    !ext_q |-> !fetch_ready_o);
endmodule

// File: rtl/xbus_pins.sv
module xbus_pins
  import xbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     seq_rst,
  input  logic                     ext_mode,
  input  slot_e                    kind,
  input  logic [QW-1:0]            q,
  input  logic [ADDR_W-1:0]        cur_addr,
  input  logic                     cur_write,
  input  logic                     cur_wide,
  input  logic [DATA_W-1:0]        cur_wdata,
  output logic                     ale_o,
  output logic                     psen_n_o,
  output logic                     rd_n_o,
  output logic                     wr_n_o,
  output logic [DATA_W-1:0]        ad_o,
  output logic                     ad_oe_o,
  output logic [ADDR_W-DATA_W-1:0] hi_addr_o,
  output logic                     hi_addr_oe_o
);
  logic addr_ph, strb_ph, xfer, addr_drv, wdata_drv, code_slot, bus_owner;

  always_comb begin
    addr_ph   = (q <= Q_ADDR_END);
    strb_ph   = (q >= Q_STRB);
    code_slot = (kind == SLOT_IDLE) || (kind == SLOT_FETCH);
    bus_owner = (kind != SLOT_IDLE) || ext_mode;
    xfer      = (kind == SLOT_DSTRB) || ((kind == SLOT_DADDR) && strb_ph);
    addr_drv  = !seq_rst && addr_ph && (kind != SLOT_DSTRB) && bus_owner;
    wdata_drv = !seq_rst && xfer && cur_write;

    ale_o    = !seq_rst && ((q == Q_ALE_A) || (q == Q_ALE_B)) && (kind != SLOT_DSTRB);
    psen_n_o = !(!seq_rst && ext_mode && code_slot && strb_ph);
    rd_n_o   = !(!seq_rst && xfer && !cur_write);
    wr_n_o   = !(!seq_rst && xfer && cur_write);
    ad_oe_o  = addr_drv || wdata_drv;
    ad_o     = addr_drv ? cur_addr[DATA_W-1:0] : cur_wdata;

    hi_addr_o    = cur_addr[ADDR_W-1:DATA_W];
    hi_addr_oe_o = !seq_rst && ((kind == SLOT_FETCH) || (kind == SLOT_IDLE && ext_mode)
                   || (((kind == SLOT_DADDR) || (kind == SLOT_DSTRB)) && cur_wide));
  end

  assert_strobes_exclusive_R12: assert property (@(posedge clk) disable iff (seq_rst)
    !(!rd_n_o && !wr_n_o));
  assert_read_float_R9: assert property (@(posedge clk) disable iff (seq_rst)
    !rd_n_o |-> !ad_oe_o);
  assert_strobe_start_R8: assert property (@(posedge clk) disable iff (seq_rst)
    ($fell(rd_n_o) || $fell(wr_n_o)) |-> (q == Q_STRB && kind == SLOT_DADDR));
  assert_ale_rise_R4: assert property (@(posedge clk) disable iff (seq_rst)
    $rose(ale_o) |-> (q == Q_ALE_A));
endmodule

// File: rtl/xbus_sequencer.sv
module xbus_sequencer
  import xbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int RST_MC = 2
) (
  input  logic                     clk,
  input  logic                     rst_in,
  input  logic                     ext_code_n_i,
  input  logic                     fetch_valid_i,
  output logic                     fetch_ready_o,
  input  logic [ADDR_W-1:0]        fetch_addr_i,
  output logic                     code_valid_o,
  output logic [DATA_W-1:0]        code_data_o,
  input  logic                     dreq_valid_i,
  output logic                     dreq_ready_o,
  input  logic                     dreq_write_i,
  input  logic                     dreq_wide_i,
  input  logic [ADDR_W-1:0]        dreq_addr_i,
  input  logic [DATA_W-1:0]        dreq_wdata_i,
  output logic                     rdata_valid_o,
  output logic [DATA_W-1:0]        rdata_o,
  output logic                     ale_o,
  output logic                     psen_n_o,
  output logic                     rd_n_o,
  output logic                     wr_n_o,
  output logic [DATA_W-1:0]        ad_o,
  output logic                     ad_oe_o,
  input  logic [DATA_W-1:0]        ad_i,
  output logic [ADDR_W-DATA_W-1:0] hi_addr_o,
  output logic                     hi_addr_oe_o
);
  localparam int RST_HOLD = RST_MC * PH_PER_MC;

  logic              seq_rst, last, ext_mode, cur_write, cur_wide;
  logic [QW-1:0]     q;
  slot_e             kind;
  logic [ADDR_W-1:0] cur_addr;
  logic [DATA_W-1:0] cur_wdata;

  xbus_reset_filter #(.HOLD(RST_HOLD)) u_rst (
    .clk(clk), .rst_in(rst_in), .seq_rst_o(seq_rst));

  xbus_phase_gen u_phase (
    .clk(clk), .seq_rst(seq_rst), .q_o(q), .last_o(last));

  xbus_slot_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .seq_rst(seq_rst), .last_i(last), .ext_code_n_i(ext_code_n_i),
    .fetch_valid_i(fetch_valid_i), .fetch_ready_o(fetch_ready_o),
    .fetch_addr_i(fetch_addr_i), .code_valid_o(code_valid_o),
    .code_data_o(code_data_o), .dreq_valid_i(dreq_valid_i),
    .dreq_ready_o(dreq_ready_o), .dreq_write_i(dreq_write_i),
    .dreq_wide_i(dreq_wide_i), .dreq_addr_i(dreq_addr_i),
    .dreq_wdata_i(dreq_wdata_i), .rdata_valid_o(rdata_valid_o),
    .rdata_o(rdata_o), .ad_i(ad_i), .ext_mode_o(ext_mode), .kind_o(kind),
    .cur_addr_o(cur_addr), .cur_write_o(cur_write), .cur_wide_o(cur_wide),
    .cur_wdata_o(cur_wdata));

  xbus_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .clk(clk), .seq_rst(seq_rst), .ext_mode(ext_mode), .kind(kind), .q(q),
    .cur_addr(cur_addr), .cur_write(cur_write), .cur_wide(cur_wide),
    .cur_wdata(cur_wdata), .ale_o(ale_o), .psen_n_o(psen_n_o), .rd_n_o(rd_n_o),
    .wr_n_o(wr_n_o), .ad_o(ad_o), .ad_oe_o(ad_oe_o), .hi_addr_o(hi_addr_o),
    .hi_addr_oe_o(hi_addr_oe_o));

  assert_psen_internal_R5: assert property (@(posedge clk) disable iff (seq_rst)
    !ext_mode |-> psen_n_o);
  assert_reset_quiet_R2: assert property (@(posedge clk)
    seq_rst |-> (!ale_o && psen_n_o && rd_n_o && wr_n_o && !ad_oe_o));
endmodule

// File: tb/xbus_sequencer_tb.sv
module xbus_sequencer_tb;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_in = 1'b0, ext_code_n = 1'b0;
  logic fetch_valid = 1'b0, fetch_ready;
  logic [15:0] fetch_addr = '0;
  logic code_valid; logic [7:0] code_data;
  logic dreq_valid = 1'b0, dreq_ready, dreq_write = 1'b0, dreq_wide = 1'b0;
  logic [15:0] dreq_addr = '0;
  logic [7:0] dreq_wdata = '0;
  logic rdata_valid; logic [7:0] rdata;
  logic ale, psen_n, rd_n, wr_n, ad_oe, hi_oe;
  logic [7:0] ad_o, hi_addr;
  logic [7:0] ad_i = '0;

  xbus_sequencer u_dut (
    .clk(clk), .rst_in(rst_in), .ext_code_n_i(ext_code_n),
    .fetch_valid_i(fetch_valid), .fetch_ready_o(fetch_ready), .fetch_addr_i(fetch_addr),
    .code_valid_o(code_valid), .code_data_o(code_data),
    .dreq_valid_i(dreq_valid), .dreq_ready_o(dreq_ready), .dreq_write_i(dreq_write),
    .dreq_wide_i(dreq_wide), .dreq_addr_i(dreq_addr), .dreq_wdata_i(dreq_wdata),
    .rdata_valid_o(rdata_valid), .rdata_o(rdata),
    .ale_o(ale), .psen_n_o(psen_n), .rd_n_o(rd_n), .wr_n_o(wr_n),
    .ad_o(ad_o), .ad_oe_o(ad_oe), .ad_i(ad_i), .hi_addr_o(hi_addr), .hi_addr_oe_o(hi_oe));

  int checks = 0, fails = 0, bph = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h (phase %0d)", tag, act, exp, bph);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    bph = (bph == 11) ? 0 : bph + 1;
  endtask

  task automatic wait_q(input int q);
    while ((bph % 6) != q) tick();
  endtask

  function automatic logic ale_exp(input int p);
    return ((p % 6) == 1) || ((p % 6) == 2);
  endfunction

  task automatic do_reset(input logic ext_n);
    @(negedge clk);
    rst_in = 1'b0; ext_code_n = ext_n;
    @(negedge clk);
    rst_in = 1'b1;
    repeat (30) @(negedge clk);
    chk("R2 reset quiet", {ale, psen_n, rd_n, wr_n, ad_oe, hi_oe}, 6'b011100);
    rst_in = 1'b0;
    @(negedge clk);
    bph = 0;
  endtask

  task automatic t_reset_cadence();
    int ale_bad = 0, psen_bad = 0;
    do_reset(1'b0);
    for (int i = 0; i < 24; i++) begin
      if (ale !== ale_exp(bph)) ale_bad++;
      if (psen_n !== !((bph % 6) >= 3)) psen_bad++;
      tick();
    end
    chk("R2 R4 latch cadence after release", 16'(ale_bad), 16'd0);
    chk("R5 program store in idle external slots", 16'(psen_bad), 16'd0);
  endtask

  task automatic t_fetch(input logic [15:0] a, input logic [7:0] b);
    wait_q(5);
    fetch_valid = 1'b1; fetch_addr = a;
    #1 chk("R6 fetch ready at phase 5", {15'd0, fetch_ready}, 16'd1);
    tick(); fetch_valid = 1'b0;
    chk("R6 low address driven", {7'd0, ad_oe, ad_o}, {8'h01, a[7:0]});
    chk("R10 fetch high address", {7'd0, hi_oe, hi_addr}, {8'h01, a[15:8]});
    tick(); chk("R4 latch pulse in fetch", {15'd0, ale}, 16'd1);
    tick(); tick();
    chk("R5 R6 program store and float", {14'd0, psen_n, ad_oe}, 16'd0);
    ad_i = b;
    tick(); tick();
    tick();
    chk("R7 code byte returned", {7'd0, code_valid, code_data}, {8'h01, b});
    tick();
    chk("R7 code pulse single", {15'd0, code_valid}, 16'd0);
  endtask

  task automatic t_data(input logic wr, input logic wide, input logic [15:0] a,
                        input logic [7:0] d, input logic [7:0] rd_val);
    int bad = 0, ales = 0, psens = 0;
    logic prev_ale;
    wait_q(5);
    dreq_valid = 1'b1; dreq_write = wr; dreq_wide = wide; dreq_addr = a; dreq_wdata = d;
    #1 chk("R6 data ready at phase 5", {15'd0, dreq_ready}, 16'd1);
    tick(); dreq_valid = 1'b0; ad_i = rd_val;
    chk("R6 data low address", {7'd0, ad_oe, ad_o}, {8'h01, a[7:0]});
    prev_ale = 1'b0;
    for (int i = 0; i < 12; i++) begin
      int q = i % 6;
      logic strobe = (i >= 3);
      if (ale && !prev_ale) ales++;
      prev_ale = ale;
      if (!psen_n) psens++;
      if (wr) begin
        if (wr_n !== !strobe || rd_n !== 1'b1) bad++;
        if (strobe && (ad_oe !== 1'b1 || ad_o !== d)) bad++;
      end else begin
        if (rd_n !== !strobe || wr_n !== 1'b1) bad++;
        if (strobe && ad_oe !== 1'b0) bad++;
      end
      if (hi_oe !== wide || (wide && hi_addr !== a[15:8])) bad++;
      if (i < 11) tick();
      if (q == 5 && i == 5) chk("R11 nothing taken mid transfer", {14'd0, dreq_ready, fetch_ready}, 16'd0);
    end
    chk(wr ? "R8 R9 write strobe and data" : "R8 R9 read strobe and float", 16'(bad), 16'd0);
    chk("R10 high address per width", 16'(bad), 16'd0);
    chk("R8 one latch pulse kept", 16'(ales), 16'd1);
    chk("R8 program store pulses skipped", 16'(psens), 16'd0);
    tick();
    chk("R12 strobes released", {14'd0, rd_n, wr_n}, 16'd3);
    if (!wr) chk("R9 read data returned", {7'd0, rdata_valid, rdata}, {8'h01, rd_val});
    tick();
    if (!wr) chk("R9 read pulse single", {15'd0, rdata_valid}, 16'd0);
  endtask

  task automatic t_priority();
    wait_q(5);
    dreq_valid = 1'b1; dreq_write = 1'b0; dreq_wide = 1'b1; dreq_addr = 16'h4321;
    fetch_valid = 1'b1; fetch_addr = 16'h0F0F;
    #1 chk("R11 data wins over fetch", {14'd0, dreq_ready, fetch_ready}, 16'b10);
    tick(); dreq_valid = 1'b0;
    chk("R11 data address on bus", 16'(ad_o), 16'h21);
    wait_q(5);
    #1 chk("R11 fetch held during first slot", {15'd0, fetch_ready}, 16'd0);
    tick(); wait_q(5);
    #1 chk("R11 fetch taken after transfer", {15'd0, fetch_ready}, 16'd1);
    tick(); fetch_valid = 1'b0;
    chk("R6 fetch follows transfer", {7'd0, ad_oe, ad_o}, 16'h010F);
  endtask

  task automatic t_short_reset();
    int bad = 0;
    rst_in = 1'b1;
    for (int i = 0; i < 23; i++) begin
      if (ale !== ale_exp(bph)) bad++;
      tick();
    end
    rst_in = 1'b0;
    for (int i = 0; i < 14; i++) begin
      if (ale !== ale_exp(bph)) bad++;
      tick();
    end
    chk("R1 short reset pulse ignored", 16'(bad), 16'd0);
  endtask

  task automatic t_internal();
    int psens = 0, ales = 0, drv = 0;
    logic prev_ale = 1'b0;
    do_reset(1'b1);
    for (int i = 0; i < 12; i++) begin
      if (!psen_n) psens++;
      if (ale && !prev_ale) ales++;
      if (ad_oe) drv++;
      prev_ale = ale;
      tick();
    end
    chk("R5 no program store internal", 16'(psens), 16'd0);
    chk("R4 two latch pulses per cycle", 16'(ales), 16'd2);
    chk("R3 idle port undriven internal", 16'(drv), 16'd0);
    wait_q(5);
    fetch_valid = 1'b1;
    #1 chk("R3 fetch refused internal", {15'd0, fetch_ready}, 16'd0);
    tick(); fetch_valid = 1'b0;
  endtask

  initial begin
    t_reset_cadence();
    t_fetch(16'h1234, 8'hA5);
    t_fetch(16'hFF00, 8'h3C);
    t_data(1'b1, 1'b1, 16'hBEEF, 8'h3C, 8'h00);
    t_data(1'b0, 1'b0, 16'h0042, 8'h00, 8'h5A);
    t_data(1'b0, 1'b1, 16'h8001, 8'h00, 8'hC3);
    t_priority();
    t_short_reset();
    t_internal();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule